// File: doc/BRIEF.md
# Counted Pulse Train Generator

This block drives one output pin with a burst of evenly spaced pulses. A configuration word sets how many clocks one base period lasts and a threshold that decides which part of each period is high. Writing a non-zero burst count starts the burst. The block then emits exactly that many base periods and raises a completion flag. Nothing else drives the pin, so the pin is low whenever no burst is running.

A period counter runs freely while the block is enabled. It counts down from the effective period to 1 and then reloads. A burst never starts in the middle of a period: after a count write, output begins on the cycle the counter reloads. Inside a running period the pin is high exactly while the counter is above the threshold, so the high part always comes at the start of the period. The count decrements on the last cycle of each period. When it reaches zero, the pin returns low and the completion flag stays up until the next count write. Dropping the enable input acts as a reset.

The controller has four states. ST_IDLE means no burst. ST_WAIT means a count has been written and the block is waiting for the period boundary. ST_RUN means periods are being emitted. ST_DONE means the burst is complete. The transitions are:
- ST_IDLE to ST_WAIT on a non-zero write in mid-period.
- ST_IDLE, ST_WAIT or ST_DONE to ST_RUN on a non-zero write on the last cycle of a period.
- ST_WAIT to ST_RUN at the boundary.
- ST_RUN to ST_DONE when the final period ends.
- Any state to ST_IDLE on a zero write or on disable.
- Any state to ST_WAIT or ST_RUN on a non-zero rewrite (restart).

Top module: `pcg_pulse_out`

## Requirements
- R1: While `en` is low, the pin and the completion flag are low, the count is cleared and the configuration is cleared to zero (effective period 2, threshold 0).
- R2: A configuration write with `en` high loads the period from `cfg_word[15:0]` and the threshold from `cfg_word[31:16]`. Both take effect in the cycle after the write.
- R3: The period counter runs whenever `en` is high. It counts from the effective period down to 1 and then reloads. A period value of 0 or 1 is treated as 2.
- R4: After a non-zero count write, the first emitted period starts on the cycle the period counter reloads. If the write lands on the last cycle of a period, emission starts in the very next cycle.
- R5: During an emitted period, the pin is high exactly on the cycles where the period counter is strictly greater than the threshold. With period 3 and threshold 2, one clock in three is high.
- R6: The count drops by one at the end of each emitted period. When it reaches zero, the pin goes low and the completion flag rises.
- R7: With threshold 0, the pin stays high continuously for count × period cycles.
- R8: The completion flag holds until the next count write. A count write clears it in the following cycle.
- R9: Writing a count of zero stops any burst: from the next cycle the pin is low, the flag is low and the block is idle.
- R10: Writing a non-zero count during a burst restarts it. Exactly the new count of periods is emitted, again aligned to a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| en | input | 1 | Enable. Low holds the block in reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 32 | Threshold in [31:16], period in [15:0] |
| cnt_wr | input | 1 | Burst count write strobe |
| cnt_word | input | 32 | Number of periods to emit |
| pin_out | output | 1 | Pulse output pin |
| done_flag | output | 1 | Burst complete flag |

## Verification
The hardest situation to reach is a count write landing on each possible phase of the free-running period counter. This matters most when the write falls on the reload cycle itself, which decides whether emission starts at once or waits a whole period. The bench sweeps the idle gap before the write across every phase of a short period. The behavioural model, compared on every clock, then catches any misaligned start. Restarts and zero writes are also issued mid-burst, at phases that differ from the boundary.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } burst_state_e;
endpackage

// File: rtl/pcg_cfg_reg.sv
module pcg_cfg_reg #(
    parameter int PER_W   = 16,
    parameter int MIN_PER = 2
) (
    input  logic               clk,
    input  logic               en,
    input  logic               wr,
    input  logic [2*PER_W-1:0] word,
    output logic [PER_W-1:0]   per_eff,
    output logic [PER_W-1:0]   thr
);
    localparam logic [PER_W-1:0] PER_FLOOR = PER_W'(MIN_PER);

    logic [PER_W-1:0] per_q;

    always_ff @(posedge clk) begin
        if (!en) begin
            per_q <= '0;
            thr   <= '0;
        end else if (wr) begin
            per_q <= word[PER_W-1:0];
            thr   <= word[PER_W +: PER_W];
        end
    end

    generate
        if (MIN_PER > 0) begin : g_clamp
            assign per_eff = (per_q < PER_FLOOR) ? PER_FLOOR : per_q;
        end else begin : g_raw
            assign per_eff = per_q;
        end
    endgenerate
endmodule

// File: rtl/pcg_period_timer.sv
module pcg_period_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             en,
    input  logic [PER_W-1:0] per_eff,
    output logic [PER_W-1:0] pc,
    output logic             last
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    assign last = (pc <= ONE);

    always_ff @(posedge clk) begin
        if (!en)       pc <= ONE;
        else if (last) pc <= per_eff;
        else           pc <= pc - ONE;
    end

    AST_RELOAD_AT_END: assert property (@(posedge clk) disable iff (!en)
        last |=> (pc == $past(per_eff)));                    // R3
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!en)
        !last |=> (pc == $past(pc) - ONE));                  // R3
endmodule

// File: rtl/pcg_burst_ctrl.sv
module pcg_burst_ctrl
    import pcg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_word,
    input  logic             last,
    output logic             running,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    burst_state_e     state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        state <= state_n;
        cnt   <= cnt_n;
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (!en) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
        end else if (cnt_wr) begin
            cnt_n = cnt_word;
            if (cnt_word == '0) state_n = ST_IDLE;
            else if (last)      state_n = ST_RUN;
            else                state_n = ST_WAIT;
        end else begin
            unique case (state)
                ST_IDLE: state_n = ST_IDLE;
                ST_WAIT: if (last) state_n = ST_RUN;
                ST_RUN: begin
                    if (last) begin
                        cnt_n = cnt - ONE;
                        if (cnt == ONE) state_n = ST_DONE;
                    end
                end
                ST_DONE: state_n = ST_DONE;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        running = (state == ST_RUN);
        done    = (state == ST_DONE);
    end

    AST_ZERO_WRITE_IDLES: assert property (@(posedge clk) disable iff (!en)
        (cnt_wr && cnt_word == '0) |=> (state == ST_IDLE));  // R9
    AST_PERIOD_DECREMENT: assert property (@(posedge clk) disable iff (!en)
        (running && last && cnt > ONE && !cnt_wr) |=> (cnt == $past(cnt) - ONE)); // R6
    AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!en)
        cnt_wr |=> !done);                                   // R8
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!en)
        (done && !cnt_wr) |=> done);                         // R8
endmodule

// File: rtl/pcg_pulse_out.sv
module pcg_pulse_out #(
    parameter int PER_W   = 16,
    parameter int CNT_W   = 32,
    parameter int MIN_PER = 2
) (
    input  logic               clk,
    input  logic               en,
    input  logic               cfg_wr,
    input  logic [2*PER_W-1:0] cfg_word,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_word,
    output logic               pin_out,
    output logic               done_flag
);
    logic [PER_W-1:0] per_eff, thr, pc;
    logic             last, running;

    pcg_cfg_reg #(.PER_W(PER_W), .MIN_PER(MIN_PER)) i_cfg (
        .clk(clk), .en(en), .wr(cfg_wr), .word(cfg_word),
        .per_eff(per_eff), .thr(thr)
    );

    pcg_period_timer #(.PER_W(PER_W)) i_timer (
        .clk(clk), .en(en), .per_eff(per_eff), .pc(pc), .last(last)
    );

    pcg_burst_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk(clk), .en(en), .cnt_wr(cnt_wr), .cnt_word(cnt_word),
        .last(last), .running(running), .done(done_flag)
    );

    assign pin_out = running && (pc > thr);

    AST_DONE_PIN_LOW: assert property (@(posedge clk) disable iff (!en)
        done_flag |-> !pin_out);                             // R6
    AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!en)
        $rose(running) |-> (pc == $past(per_eff)));          // R4
endmodule

// File: tb/test_pcg_pulse_out.sv
module test_pcg_pulse_out;
    logic        clk = 1'b0;
    logic        en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        cnt_wr = 1'b0;
    logic [31:0] cnt_word = '0;
    logic        pin_out, done_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int     m_per = 0, m_thr = 0, m_ph = 1, m_mode = 0;
    longint m_cnt = 0;

    always #10 clk = ~clk;

    pcg_pulse_out i_pcg_pulse_out (
        .clk(clk), .en(en), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .cnt_wr(cnt_wr), .cnt_word(cnt_word),
        .pin_out(pin_out), .done_flag(done_flag)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic chk_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model: mode 0 idle, 1 waiting, 2 emitting, 3 complete
    always @(posedge clk) begin
        cycles++;
        if (!en) begin
            m_per = 0; m_thr = 0; m_ph = 1; m_cnt = 0; m_mode = 0;
        end else begin
            int  eff;
            bit  edge_end;
            eff      = (m_per < 2) ? 2 : m_per;
            edge_end = (m_ph == 1);
            if (cnt_wr) begin
                m_cnt = longint'(cnt_word);
                if (cnt_word == 0) m_mode = 0;
                else m_mode = edge_end ? 2 : 1;
            end else if (m_mode == 1 && edge_end) begin
                m_mode = 2;
            end else if (m_mode == 2 && edge_end) begin
                m_cnt--;
                if (m_cnt == 0) m_mode = 3;
            end
            m_ph = edge_end ? eff : m_ph - 1;
            if (cfg_wr) begin
                m_per = int'(cfg_word[15:0]);
                m_thr = int'(cfg_word[31:16]);
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, "pin_out", pin_out, (m_mode == 2) && (m_ph > m_thr));
            chk(cur_req, "done_flag", done_flag, m_mode == 3);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cfg(int per, int thr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_word = {thr[15:0], per[15:0]};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // write count then count high cycles until done
    task automatic burst(string req, int y, int exp_hi);
        int hi = 0;
        int n  = 0;
        cnt_wr = 1'b1; cnt_word = y;
        @(negedge clk);
        cnt_wr = 1'b0;
        chk(req, "done cleared after write", done_flag, 1'b0);
        while (!done_flag && n < 5000) begin
            if (pin_out) hi++;
            @(negedge clk);
            n++;
        end
        chk(req, "completion reached", done_flag, 1'b1);
        chk_int(req, "high cycles in burst", hi, exp_hi);
    endtask

    initial begin
        // R1: held disabled
        idle(3);
        cmp_on = 1'b1;
        cur_req = "R1";
        idle(2);
        chk("R1", "pin low in reset", pin_out, 1'b0);
        chk("R1", "flag low in reset", done_flag, 1'b0);
        en = 1'b1;

        // R2 / R5: period 3 threshold 2 -> one high per period
        cur_req = "R5";
        set_cfg(3, 2);
        burst("R5", 4, 4);
        cur_req = "R2";
        set_cfg(6, 2);
        burst("R2", 3, 12);

        // R7: threshold zero, continuous high
        cur_req = "R7";
        set_cfg(5, 0);
        burst("R7", 3, 15);

        // R3: small periods clamp to two
        cur_req = "R3";
        set_cfg(0, 0);
        burst("R3", 2, 4);
        set_cfg(1, 1);
        burst("R3", 3, 3);

        // R8: flag holds, then a write clears it
        cur_req = "R8";
        idle(10);
        chk("R8", "flag held while idle", done_flag, 1'b1);
        chk("R8", "pin low after completion", pin_out, 1'b0);

        // R4: sweep write phase against the period counter
        cur_req = "R4";
        set_cfg(5, 4);
        for (int g = 0; g < 6; g++) begin
            idle(g);
            burst("R4", 2, 2);
        end

        // R6: threshold above period gives no high, still completes
        cur_req = "R6";
        set_cfg(4, 9);
        burst("R6", 3, 0);
        set_cfg(7, 3);
        burst("R6", 5, 20);

        // R9: zero write mid-burst
        cur_req = "R9";
        set_cfg(4, 1);
        cnt_wr = 1'b1; cnt_word = 100;
        @(negedge clk);
        cnt_wr = 1'b0;
        idle(9);
        cnt_wr = 1'b1; cnt_word = 0;
        @(negedge clk);
        cnt_wr = 1'b0;
        chk("R9", "pin low after zero write", pin_out, 1'b0);
        idle(20);
        chk("R9", "flag low after zero write", done_flag, 1'b0);

        // R10: restart mid-burst with a new count
        cur_req = "R10";
        set_cfg(5, 2);
        cnt_wr = 1'b1; cnt_word = 50;
        @(negedge clk);
        cnt_wr = 1'b0;
        idle(7);
        burst("R10", 2, 6);

        // R1: disable in the middle of a burst
        cur_req = "R1";
        set_cfg(3, 0);
        cnt_wr = 1'b1; cnt_word = 40;
        @(negedge clk);
        cnt_wr = 1'b0;
        idle(5);
        en = 1'b0;
        idle(2);
        chk("R1", "pin low after disable", pin_out, 1'b0);
        en = 1'b1;
        cur_req = "R1";
        burst("R1", 2, 4);

        idle(4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule